// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Bridge

This block carries a processor core's data-memory accesses out to an external asynchronous SRAM over a narrow multiplexed bus. The low address byte and the data byte share one 8-bit port. The high address byte has a dedicated port of its own. An address strobe (`ale`) lets a transparent latch on the board hold the low address byte while the shared port carries data. Active-low read and write strobes then complete the access.

A mode input selects the pin use. With `bus_en` clear, both ports simply follow the general-purpose drive, direction and pull-up settings supplied from outside. With `bus_en` set, the bridge takes over both ports and the three control strobes. It then starts a bus cycle only for addresses above a configurable internal-memory ceiling.

Each external access follows a fixed sequence:
- an address phase of one cycle with `ale` high;
- a data phase of `WAIT_CYC` cycles with exactly one strobe low;
- a closing cycle with both strobes released and `rsp_done` pulsed.

Top module: `xmem_mux_bridge`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `rd_n` and `wr_n` are 1 and `rsp_done` is 0.
- R2: With `bus_en` = 0, `pa_out`/`pa_oe`/`pc_out`/`pc_oe` equal `gpa_dout`/`gpa_dir`/`gpc_dout`/`gpc_dir`, and `pa_pu` = `gpa_dout & ~gpa_dir`. No bus cycle starts, even for external addresses.
- R3: With `bus_en` = 1, all eight `pa_pu` bits are 1 and `pc_oe` is all ones. The shared port is released (`pa_oe` = 0) while no transfer is in progress.
- R4: A request with `req_valid` = 1 is accepted on a clock edge while the bridge is idle. The cycle after acceptance is the address phase. In that cycle `ale` = 1, `pa_oe` is all ones and `pa_out` = `req_addr[7:0]`. `ale` is high for exactly that one cycle.
- R5: The data phase lasts `WAIT_CYC` cycles. Throughout it, `ale` = 0 and exactly one strobe is low: `wr_n` if `req_we` = 1, otherwise `rd_n`.
- R6: For a write, the shared port drives `req_wdata` from the first data-phase cycle through the closing cycle.
- R7: For a read, the shared port is released from the data phase onward. `pa_in` is sampled on the last cycle of the data phase only, and that value appears on `rsp_rdata` during the `rsp_done` cycle.
- R8: A request whose address is at or below `INT_TOP` produces no `ale` pulse, no strobe and no `rsp_done`. With the default `INT_TOP` of 0x045F, 0x045F is internal and 0x0460 is external.
- R9: `rsp_done` is high for exactly one cycle, the cycle right after the strobe is released. A request presented while a transfer is in progress is ignored.
- R10: `pc_out` carries `req_addr[15:8]` for every cycle of a transfer and does not change during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | 1 = external bus mode, 0 = general-purpose pins |
| req_valid | input | 1 | Core access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| gpa_dout | input | 8 | General-purpose drive value, shared port |
| gpa_dir | input | 8 | General-purpose direction, shared port (1 = output) |
| gpc_dout | input | 8 | General-purpose drive value, high port |
| gpc_dir | input | 8 | General-purpose direction, high port |
| pa_in | input | 8 | Pin levels of the shared port |
| pa_out | output | 8 | Shared port drive value |
| pa_oe | output | 8 | Shared port output enable |
| pa_pu | output | 8 | Shared port pull-up enable |
| pc_out | output | 8 | High port drive value |
| pc_oe | output | 8 | High port output enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions take for granted that `bus_en` is held steady while a transfer is in flight. They also assume a request's address, direction and write data are consulted only on the edge that accepts it. The stimulus changes `bus_en` and the general-purpose settings only after every outstanding completion has been seen, and it waits out each transfer before moving on. The one exception is a deliberate extra request placed in the middle of a transfer, which must be ignored. The bench's SRAM model drives read data only on the final data-phase cycle, so sampling one cycle early yields a visibly wrong byte.

// File: rtl/xmem_bridge_pkg.sv
package xmem_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } xb_phase_e;

  // address lies beyond the on-chip memory ceiling
  function automatic logic is_external(input int unsigned addr, input int unsigned ceiling);
    return addr > ceiling;
  endfunction

  // final data-phase cycle for a given wait count
  function automatic logic wait_done(input int unsigned cnt, input int unsigned waits);
    return cnt == waits - 1;
  endfunction

  // pull-up rule for a general-purpose port: input pins with a 1 drive value
  function automatic logic [7:0] gp_pullup(input logic [7:0] dout, input logic [7:0] dir);
    return dout & ~dir;
  endfunction

endpackage

// File: rtl/xmem_addr_decode.sv
module xmem_addr_decode
  import xmem_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h045F
) (
  input  logic              bus_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              seq_idle,
  output logic              ev_external,
  output logic              ev_accept
);

  always_comb begin
    ev_external = is_external(32'(req_addr), 32'(INT_TOP));
    ev_accept   = seq_idle && bus_en && req_valid && ev_external;
  end

endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmem_bridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W-1:0]        pa_in,
  output logic                     seq_idle,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     drive_lo,
  output logic [DATA_W-1:0]        lo_val,
  output logic [ADDR_W-DATA_W-1:0] hi_val,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam int CW   = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

  xb_phase_e          ph;
  logic [CW-1:0]      cnt;
  logic               we_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               ev_strobe_last;

  assign ev_strobe_last = (ph == PH_DATA) && wait_done(32'(cnt), WAIT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (accept) begin
          ph      <= PH_ADDR;
          we_q    <= req_we;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        PH_ADDR: begin
          ph  <= PH_DATA;
          cnt <= '0;
        end
        PH_DATA: begin
          if (ev_strobe_last) begin
            ph <= PH_DONE;
            if (!we_q) rdata_q <= pa_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    seq_idle = (ph == PH_IDLE);
    ale_o    = (ph == PH_ADDR);
    rd_n_o   = !((ph == PH_DATA) && !we_q);
    wr_n_o   = !((ph == PH_DATA) && we_q);
    drive_lo = (ph == PH_ADDR) || (((ph == PH_DATA) || (ph == PH_DONE)) && we_q);
    lo_val   = (ph == PH_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
    hi_val   = addr_q[ADDR_W-1:DATA_W];
    done_o   = (ph == PH_DONE);
    rdata_o  = rdata_q;
  end

  // R5: never both strobes low
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  // R5: address strobe low while a data strobe is active
  a_r5_ale_low_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> !ale_o);
  // R4: address strobe lasts one cycle and is followed by a strobe
  a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (!ale_o && (!rd_n_o || !wr_n_o)));
  // R9: completion follows a strobe cycle
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(!rd_n_o || !wr_n_o) && rd_n_o && wr_n_o));
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6: write data stays put through the strobe
  a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o && $past(!wr_n_o)) |-> ($stable(lo_val) && drive_lo));
  // R7: shared port released while reading
  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !drive_lo);
  // R10: high address byte steady during a transfer
  a_r10_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && $past(!seq_idle)) |-> $stable(hi_val));

endmodule

// File: rtl/xmem_pin_mux.sv
module xmem_pin_mux
  import xmem_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input  logic              bus_en,
  input  logic              seq_ale,
  input  logic              seq_rd_n,
  input  logic              seq_wr_n,
  input  logic              seq_drive_lo,
  input  logic [DATA_W-1:0] seq_lo,
  input  logic [HI_W-1:0]   seq_hi,
  input  logic [DATA_W-1:0] gpa_dout,
  input  logic [DATA_W-1:0] gpa_dir,
  input  logic [HI_W-1:0]   gpc_dout,
  input  logic [HI_W-1:0]   gpc_dir,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  output logic [DATA_W-1:0] pa_pu,
  output logic [HI_W-1:0]   pc_out,
  output logic [HI_W-1:0]   pc_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);

  always_comb begin
    if (bus_en) begin
      pa_out = seq_lo;
      pa_oe  = {DATA_W{seq_drive_lo}};
      pa_pu  = '1;
      pc_out = seq_hi;
      pc_oe  = '1;
      ale    = seq_ale;
      rd_n   = seq_rd_n;
      wr_n   = seq_wr_n;
    end else begin
      pa_out = gpa_dout;
      pa_oe  = gpa_dir;
      pa_pu  = gp_pullup(8'(gpa_dout), 8'(gpa_dir))[DATA_W-1:0];
      pc_out = gpc_dout;
      pc_oe  = gpc_dir;
      ale    = 1'b0;
      rd_n   = 1'b1;
      wr_n   = 1'b1;
    end
  end

endmodule

// File: rtl/xmem_mux_bridge.sv
module xmem_mux_bridge
  import xmem_bridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h045F,
  parameter int WAIT_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     req_valid,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_done,
  input  logic [DATA_W-1:0]        gpa_dout,
  input  logic [DATA_W-1:0]        gpa_dir,
  input  logic [ADDR_W-DATA_W-1:0] gpc_dout,
  input  logic [ADDR_W-DATA_W-1:0] gpc_dir,
  input  logic [DATA_W-1:0]        pa_in,
  output logic [DATA_W-1:0]        pa_out,
  output logic [DATA_W-1:0]        pa_oe,
  output logic [DATA_W-1:0]        pa_pu,
  output logic [ADDR_W-DATA_W-1:0] pc_out,
  output logic [ADDR_W-DATA_W-1:0] pc_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              seq_idle;
  logic              ev_external;
  logic              ev_accept;
  logic              seq_ale, seq_rd_n, seq_wr_n, seq_drive_lo;
  logic [DATA_W-1:0] seq_lo;
  logic [HI_W-1:0]   seq_hi;

  xmem_addr_decode #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) i_decode (
    .bus_en      (bus_en),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .seq_idle    (seq_idle),
    .ev_external (ev_external),
    .ev_accept   (ev_accept)
  );

  xmem_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ev_accept),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .pa_in     (pa_in),
    .seq_idle  (seq_idle),
    .ale_o     (seq_ale),
    .rd_n_o    (seq_rd_n),
    .wr_n_o    (seq_wr_n),
    .drive_lo  (seq_drive_lo),
    .lo_val    (seq_lo),
    .hi_val    (seq_hi),
    .done_o    (rsp_done),
    .rdata_o   (rsp_rdata)
  );

  xmem_pin_mux #(.DATA_W(DATA_W), .HI_W(HI_W)) i_pins (
    .bus_en       (bus_en),
    .seq_ale      (seq_ale),
    .seq_rd_n     (seq_rd_n),
    .seq_wr_n     (seq_wr_n),
    .seq_drive_lo (seq_drive_lo),
    .seq_lo       (seq_lo),
    .seq_hi       (seq_hi),
    .gpa_dout     (gpa_dout),
    .gpa_dir      (gpa_dir),
    .gpc_dout     (gpc_dout),
    .gpc_dir      (gpc_dir),
    .pa_out       (pa_out),
    .pa_oe        (pa_oe),
    .pa_pu        (pa_pu),
    .pc_out       (pc_out),
    .pc_oe        (pc_oe),
    .ale          (ale),
    .rd_n         (rd_n),
    .wr_n         (wr_n)
  );

  // R8: a request for on-chip memory leaves the sequencer idle
  a_r8_internal_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && req_valid && !ev_external) |=> seq_idle);
  // R2: nothing starts while the bus mode is off
  a_r2_off_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !bus_en) |=> seq_idle);
  // R3: shared port released whenever the bridge is idle in bus mode
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && seq_idle) |-> (pa_oe == '0));

endmodule

// File: tb/test_xmem_mux_bridge.sv
`timescale 1ns/1ps
module test_xmem_mux_bridge;

  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic [7:0]  gpa_dout = '0, gpa_dir = '0, gpc_dout = '0, gpc_dir = '0;
  logic [7:0]  pa_in;
  logic [7:0]  pa_out, pa_oe, pa_pu, pc_out, pc_oe;
  logic        ale, rd_n, wr_n;

  always #2.5 clk = ~clk;

  xmem_mux_bridge #(.WAIT_CYC(W)) i_xmem_mux_bridge (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .gpa_dout(gpa_dout), .gpa_dir(gpa_dir), .gpc_dout(gpc_dout), .gpc_dir(gpc_dir),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pu(pa_pu), .pc_out(pc_out),
    .pc_oe(pc_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int done_seen = 0;
  int ale_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- external SRAM with address latch ----------------
  logic [7:0] sram [int];
  logic [7:0] lat_lo = '0;
  int rd_low = 0;

  always @(posedge clk) begin
    if (ale) lat_lo <= pa_out;
    if (!wr_n) sram[{pc_out, lat_lo}] = pa_out;
    rd_low <= rd_n ? 0 : rd_low + 1;
  end

  always_comb begin
    if (!rd_n && rd_low >= W - 1)
      pa_in = sram.exists({pc_out, lat_lo}) ? sram[{pc_out, lat_lo}] : 8'h00;
    else
      pa_in = 8'h00;
  end

  // ---------------- cycle-level reference model ----------------
  typedef struct {
    bit ale, rd_n, wr_n, oe, done, we;
    logic [7:0] lo, hi, rdata;
  } exp_t;

  exp_t q[$];
  logic [7:0] ref_mem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      bit was_idle;
      was_idle = (q.size() == 0);
      if (!was_idle) void'(q.pop_front());
      if (was_idle && req_valid && bus_en && int'(req_addr) > 'h045F) begin
        exp_t e;
        logic [7:0] rv;
        rv = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
        if (req_we) ref_mem[int'(req_addr)] = req_wdata;
        e = '{ale:1, rd_n:1, wr_n:1, oe:1, done:0, we:req_we,
              lo:req_addr[7:0], hi:req_addr[15:8], rdata:rv};
        q.push_back(e);
        for (int k = 0; k < W; k++) begin
          e.ale = 0; e.rd_n = req_we; e.wr_n = !req_we; e.oe = req_we; e.lo = req_wdata;
          q.push_back(e);
        end
        e.rd_n = 1; e.wr_n = 1; e.done = 1;
        q.push_back(e);
      end
    end
  end

  always @(negedge clk) begin
    if (rsp_done) done_seen++;
    if (ale) ale_seen++;
    if (!rst_n) begin
      chk(ale == 0 && rd_n && wr_n && !rsp_done, "R1", "reset strobes",
          {12'h0, ale, rd_n, wr_n, rsp_done}, 16'h0006);
    end else if (q.size() != 0) begin
      exp_t e;
      e = q[0];
      chk(ale == e.ale, "R4", "ale", 16'(ale), 16'(e.ale));
      chk(rd_n == e.rd_n && wr_n == e.wr_n, "R5", "strobes",
          {14'h0, rd_n, wr_n}, {14'h0, e.rd_n, e.wr_n});
      chk(pa_oe == {8{e.oe}}, e.we ? "R6" : "R7", "pa_oe", 16'(pa_oe), 16'({8{e.oe}}));
      if (e.oe) chk(pa_out == e.lo, e.ale ? "R4" : "R6", "pa_out", 16'(pa_out), 16'(e.lo));
      chk(pc_out == e.hi && pc_oe == 8'hFF, "R10", "high port",
          {pc_oe, pc_out}, {8'hFF, e.hi});
      chk(pa_pu == 8'hFF, "R3", "bus pull-ups", 16'(pa_pu), 16'hFF);
      chk(rsp_done == e.done, "R9", "done", 16'(rsp_done), 16'(e.done));
      if (e.done && !e.we) chk(rsp_rdata == e.rdata, "R7", "read data",
                               16'(rsp_rdata), 16'(e.rdata));
    end else if (bus_en) begin
      chk(ale == 0 && rd_n && wr_n && !rsp_done, "R8", "idle strobes",
          {12'h0, ale, rd_n, wr_n, rsp_done}, 16'h0006);
      chk(pa_oe == 8'h00 && pa_pu == 8'hFF && pc_oe == 8'hFF, "R3", "idle bus pins",
          {pa_oe, pa_pu}, 16'h00FF);
    end else begin
      chk(pa_out == gpa_dout && pa_oe == gpa_dir, "R2", "shared port passthrough",
          {pa_oe, pa_out}, {gpa_dir, gpa_dout});
      chk(pa_pu == (gpa_dout & ~gpa_dir), "R2", "pull-up rule",
          16'(pa_pu), 16'(gpa_dout & ~gpa_dir));
      chk(pc_out == gpc_dout && pc_oe == gpc_dir, "R2", "high port passthrough",
          {pc_oe, pc_out}, {gpc_dir, gpc_dout});
      chk(ale == 0 && rd_n && wr_n && !rsp_done, "R2", "strobes idle when off",
          {12'h0, ale, rd_n, wr_n, rsp_done}, 16'h0006);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_req(input logic [15:0] a, input bit we, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_addr = 16'hxxxx; req_wdata = 8'hxx;
    repeat (W + 3) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int d0, a0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    gpa_dout = 8'h3C; gpa_dir = 8'h0F; gpc_dout = 8'h81; gpc_dir = 8'hF0;
    repeat (3) @(posedge clk);

    // R2: external address with the bus mode off starts nothing
    d0 = done_seen;
    drive_req(16'h1234, 1'b1, 8'h77);
    chk(done_seen == d0, "R2", "no transfer when off", 16'(done_seen - d0), 16'h0);

    #1 bus_en = 1'b1;
    repeat (2) @(posedge clk);

    // R6 writes, including the first external address above the ceiling
    drive_req(16'h1234, 1'b1, 8'hA5);
    drive_req(16'h0460, 1'b1, 8'h5A);
    drive_req(16'hFFFF, 1'b1, 8'hC3);
    // R7 reads back
    d0 = done_seen;
    drive_req(16'h1234, 1'b0, 8'h00);
    drive_req(16'h0460, 1'b0, 8'h00);
    drive_req(16'hFFFF, 1'b0, 8'h00);
    drive_req(16'h8000, 1'b0, 8'h00);
    chk(done_seen - d0 == 4, "R9", "one done per read", 16'(done_seen - d0), 16'h4);

    // R8: at and below the ceiling nothing happens
    d0 = done_seen; a0 = ale_seen;
    drive_req(16'h045F, 1'b1, 8'hEE);
    drive_req(16'h0100, 1'b0, 8'h00);
    drive_req(16'h0000, 1'b1, 8'h11);
    chk(done_seen == d0 && ale_seen == a0, "R8", "internal requests silent",
        {8'(done_seen - d0), 8'(ale_seen - a0)}, 16'h0);
    // R8: the write to 0x045F must not reach external memory
    chk(!sram.exists(16'h045F), "R8", "no external write", 16'(sram.exists(16'h045F)), 16'h0);

    // R9: request while busy is ignored
    d0 = done_seen;
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h2000; req_wdata = 8'h3E;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h2001; req_wdata = 8'h99;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (W + 4) @(posedge clk);
    chk(done_seen - d0 == 1, "R9", "busy request ignored", 16'(done_seen - d0), 16'h1);
    chk(!sram.exists(16'h2001), "R9", "ignored write absent", 16'(sram.exists(16'h2001)), 16'h0);
    drive_req(16'h2000, 1'b0, 8'h00);

    // R2 again with different settings
    #1 bus_en = 1'b0;
    gpa_dout = 8'hF0; gpa_dir = 8'h33; gpc_dout = 8'h5A; gpc_dir = 8'h0F;
    repeat (4) @(posedge clk);

    finish_run();
  end

endmodule